// File: doc/BRIEF.md
# Dual-Bank Configuration Register File

This block keeps two full copies of a device's working configuration: a foreground set and a background set. Each set holds six 16-bit registers: control, segment limits, address pointer, mask, source page and destination page. One special instruction picks the foreground set and another picks the background set. Every later write, access or segment operation works on the set that is active when it executes. A pair of segment counters, one for the destination side and one for the source side, steps between limits taken from the active segment register. An address pointer can be loaded from an operand and moves up or down after each memory access.

The host drives a 32-bit bus with a valid strobe. The op-code is on bits 31:16 and the operand is on bits 15:0. Every state change is registered. The registers of the active set, both counters, the full flag and the access report all appear at the ports one clock after the instruction is accepted. The memory array is not part of this block. The block reports an access as a one-cycle strobe plus the entry address it used.

Top module: `cfg_bank_regfile`

## Requirements
- R1: After reset, the foreground set (bank_o = 0) is active. All twelve registers and both counters read 0, full_n_o is 1 and acc_valid_o is 0.
- R2: The op-code 0x0900+k with k from 0 to 5 writes the operand into register k of the active set. The register numbers are: control 0, segment 1, address 2, mask 3, source page 4, destination page 5. A value written to register 2 is first reduced modulo DEPTH. The op-codes with k equal to 6 or 7 change nothing.
- R3: Op-code 0x0600 selects the foreground set and op-code 0x0601 selects the background set. The new set applies from the next instruction on. The set that is not selected keeps its contents.
- R4: Op-code 0x0602 loads the destination counter with segment bits 3:0 and the source counter with segment bits 11:8. Both values come from the active set.
- R5: Op-code 0x0B00 advances the destination counter and op-code 0x0B01 advances the source counter. A counter that equals its end limit goes back to its start limit. Otherwise it adds 1. The destination end limit is segment bits 7:4 and the source end limit is segment bits 15:12.
- R6: Op-code 0x0A00 performs an access at the current address. Op-code 0x0A01 performs an access at the operand reduced modulo DEPTH. In both cases acc_valid_o is 1 for one cycle and acc_addr_o shows the address used.
- R7: After an access, the address register becomes the used address plus 1 when control bits 1:0 are 01, and minus 1 when they are 10. Both directions wrap modulo DEPTH. Any other mode leaves the used address in place.
- R8: Op-code 0x0700 drives full_n_o low. It stays low until reset.
- R9: Op-codes outside R2 to R8 change nothing. This includes 0x0300 and special op-codes whose target field, bits 5:3, is not zero. Cycles with instr_valid low also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Bus word is an instruction this cycle |
| bus_i | input | 32 | Op-code in 31:16, operand in 15:0 |
| bank_o | output | 1 | Active set, 0 foreground, 1 background |
| ctrl_o | output | 16 | Active control register |
| segctl_o | output | 16 | Active segment-limit register |
| addr_o | output | AW | Active address register |
| mask1_o | output | 16 | Active mask register |
| page_src_o | output | 16 | Active source page register |
| page_dst_o | output | 16 | Active destination page register |
| dst_cnt_o | output | 4 | Destination segment counter |
| src_cnt_o | output | 4 | Source segment counter |
| full_n_o | output | 1 | Full flag, active low |
| acc_valid_o | output | 1 | One-cycle access report |
| acc_addr_o | output | AW | Entry address of the reported access |

## Verification
The bench builds the block with DEPTH = 12. This is not a power of two, so plain bit truncation cannot stand in for the modulo. Stepping up from entry 11 and stepping down from entry 0 can both be reached in a single access. Loaded operands above DEPTH, such as 27, exercise the folding. Segment limits of 3..6 and 2..5 keep both counter wrap points within a few instructions.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int NREGS = 6;
  localparam int DW = 16;
  localparam int SEG_W = 4;

  localparam int IDX_CTRL = 0;
  localparam int IDX_SEG = 1;
  localparam int IDX_ADDR = 2;
  localparam int IDX_MASK = 3;
  localparam int IDX_PSRC = 4;
  localparam int IDX_PDST = 5;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WRITE,
    OP_SEL_FG,
    OP_SEL_BG,
    OP_RSC,
    OP_ADV,
    OP_ACCESS,
    OP_SFF
  } op_e;

  typedef struct packed {
    op_e op;
    logic [2:0] sel;
    logic flag;
    logic [DW-1:0] arg;
  } dec_t;

  // Fold an operand into the entry range.
  function automatic logic [DW-1:0] addr_fold(input logic [DW-1:0] v, input int unsigned depth);
    int unsigned r;
    r = int'(v) % depth;
    return DW'(r);
  endfunction

  // Step an address per the control mode: 01 up, 10 down, else hold.
  function automatic logic [DW-1:0] addr_step(input logic [DW-1:0] a, input logic [1:0] mode,
                                              input int unsigned depth);
    logic [DW-1:0] last;
    last = DW'(depth - 1);
    case (mode)
      2'b01: return (a == last) ? '0 : a + 1'b1;
      2'b10: return (a == '0) ? last : a - 1'b1;
      default: return a;
    endcase
  endfunction

  // Segment counter advance: end limit returns to start limit.
  function automatic logic [SEG_W-1:0] seg_next(input logic [SEG_W-1:0] cnt,
                                                input logic [SEG_W-1:0] lo,
                                                input logic [SEG_W-1:0] hi);
    return (cnt == hi) ? lo : cnt + 1'b1;
  endfunction

endpackage

// File: rtl/instr_decode.sv
module instr_decode
  import cfgbank_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] word_i,
  output dec_t        dec_o
);
  logic [15:0] opw;
  logic is_special, is_write, is_access, is_adv, is_sff;
  logic [2:0] tgt, oper;

  assign opw = word_i[31:16];
  assign tgt = opw[5:3];
  assign oper = opw[2:0];
  assign is_special = (opw[15:6] == 10'b0000_0110_00);
  assign is_sff = (opw == 16'h0700);
  assign is_write = (opw[15:3] == 13'h0120) && (oper < 3'(NREGS));
  assign is_access = (opw[15:1] == 15'h0500);
  assign is_adv = (opw[15:1] == 15'h0580);

  always_comb begin
    dec_o.op = OP_NONE;
    dec_o.sel = oper;
    dec_o.flag = opw[0];
    dec_o.arg = word_i[15:0];
    if (valid_i) begin
      if (is_special && tgt == 3'd0) begin
        case (oper)
          3'd0: dec_o.op = OP_SEL_FG;
          3'd1: dec_o.op = OP_SEL_BG;
          3'd2: dec_o.op = OP_RSC;
          default: dec_o.op = OP_NONE;
        endcase
      end else if (is_sff) dec_o.op = OP_SFF;
      else if (is_write) dec_o.op = OP_WRITE;
      else if (is_access) dec_o.op = OP_ACCESS;
      else if (is_adv) dec_o.op = OP_ADV;
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfgbank_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en_i,
  input  logic [2:0]               wr_sel_i,
  input  logic [DW-1:0]            wr_data_i,
  output logic [NREGS-1:0][DW-1:0] regs_o
);
  logic [NREGS-1:0][DW-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else if (wr_en_i) regs_q[wr_sel_i] <= wr_data_i;
  end

  assign regs_o = regs_q;

  // R2/R3: a bank that is not written keeps every register
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(regs_q));
endmodule

// File: rtl/seg_counter.sv
module seg_counter
  import cfgbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsc_i,
  input  logic             adv_i,
  input  logic [SEG_W-1:0] lo_i,
  input  logic [SEG_W-1:0] hi_i,
  output logic [SEG_W-1:0] cnt_o
);
  logic [SEG_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (rsc_i) cnt_q <= lo_i;
    else if (adv_i) cnt_q <= seg_next(cnt_q, lo_i, hi_i);
  end

  assign cnt_o = cnt_q;

  a_r4_reset_to_start: assert property (@(posedge clk) disable iff (!rst_n)
    rsc_i |=> cnt_q == $past(lo_i));
  a_r5_count_up: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !rsc_i && cnt_q != hi_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  a_r5_wrap_end: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !rsc_i && cnt_q == hi_i) |=> cnt_q == $past(lo_i));
endmodule

// File: rtl/cfg_bank_regfile.sv
module cfg_bank_regfile
  import cfgbank_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [31:0]   bus_i,
  output logic          bank_o,
  output logic [15:0]   ctrl_o,
  output logic [15:0]   segctl_o,
  output logic [AW-1:0] addr_o,
  output logic [15:0]   mask1_o,
  output logic [15:0]   page_src_o,
  output logic [15:0]   page_dst_o,
  output logic [3:0]    dst_cnt_o,
  output logic [3:0]    src_cnt_o,
  output logic          full_n_o,
  output logic          acc_valid_o,
  output logic [AW-1:0] acc_addr_o
);
  dec_t dec;
  logic bank_q, full_n_q, acc_valid_q;
  logic [AW-1:0] acc_addr_q;
  logic [1:0][NREGS-1:0][DW-1:0] bank_regs;
  logic [NREGS-1:0][DW-1:0] act;
  logic [1:0][SEG_W-1:0] seg_cnt;

  // Named internal events
  logic ev_sel_fg, ev_sel_bg, ev_rsc, ev_adv, ev_access, ev_sff, ev_write;
  logic wr_en;
  logic [2:0] wr_sel;
  logic [DW-1:0] wr_data, acc_base;

  instr_decode u_dec (.valid_i(instr_valid), .word_i(bus_i), .dec_o(dec));

  assign ev_sel_fg = (dec.op == OP_SEL_FG);
  assign ev_sel_bg = (dec.op == OP_SEL_BG);
  assign ev_rsc = (dec.op == OP_RSC);
  assign ev_adv = (dec.op == OP_ADV);
  assign ev_access = (dec.op == OP_ACCESS);
  assign ev_sff = (dec.op == OP_SFF);
  assign ev_write = (dec.op == OP_WRITE);

  assign act = bank_regs[bank_q];

  assign acc_base = dec.flag ? addr_fold(dec.arg, DEPTH) : act[IDX_ADDR];

  always_comb begin
    wr_en = ev_write || ev_access;
    wr_sel = ev_access ? 3'(IDX_ADDR) : dec.sel;
    if (ev_access) wr_data = addr_step(acc_base, act[IDX_CTRL][1:0], DEPTH);
    else if (dec.sel == 3'(IDX_ADDR)) wr_data = addr_fold(dec.arg, DEPTH);
    else wr_data = dec.arg;
  end

  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    cfg_bank u_bank (
      .clk(clk),
      .rst_n(rst_n),
      .wr_en_i(wr_en && (bank_q == 1'(gb))),
      .wr_sel_i(wr_sel),
      .wr_data_i(wr_data),
      .regs_o(bank_regs[gb])
    );
  end

  // gs = 0 destination, gs = 1 source
  for (genvar gs = 0; gs < 2; gs++) begin : g_seg
    seg_counter u_seg (
      .clk(clk),
      .rst_n(rst_n),
      .rsc_i(ev_rsc),
      .adv_i(ev_adv && (dec.flag == 1'(gs))),
      .lo_i(act[IDX_SEG][gs*2*SEG_W +: SEG_W]),
      .hi_i(act[IDX_SEG][gs*2*SEG_W + SEG_W +: SEG_W]),
      .cnt_o(seg_cnt[gs])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      full_n_q <= 1'b1;
      acc_valid_q <= 1'b0;
      acc_addr_q <= '0;
    end else begin
      if (ev_sel_fg) bank_q <= 1'b0;
      else if (ev_sel_bg) bank_q <= 1'b1;
      if (ev_sff) full_n_q <= 1'b0;
      acc_valid_q <= ev_access;
      if (ev_access) acc_addr_q <= acc_base[AW-1:0];
    end
  end

  assign bank_o = bank_q;
  assign ctrl_o = act[IDX_CTRL];
  assign segctl_o = act[IDX_SEG];
  assign addr_o = act[IDX_ADDR][AW-1:0];
  assign mask1_o = act[IDX_MASK];
  assign page_src_o = act[IDX_PSRC];
  assign page_dst_o = act[IDX_PDST];
  assign dst_cnt_o = seg_cnt[0];
  assign src_cnt_o = seg_cnt[1];
  assign full_n_o = full_n_q;
  assign acc_valid_o = acc_valid_q;
  assign acc_addr_o = acc_addr_q;

  a_r7_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    act[IDX_ADDR] < DW'(DEPTH));
  a_r6_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid_o |-> (32'(acc_addr_o) < DEPTH));
  a_r8_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n_o |=> !full_n_o);
  a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_sel_fg || ev_sel_bg) |=> $stable(bank_o));
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> ($stable({bank_o, bank_regs, dst_cnt_o, src_cnt_o, full_n_o}) && !acc_valid_o));
endmodule

// File: tb/tb_cfg_bank_regfile.sv
module tb_cfg_bank_regfile;
  localparam int D = 12;
  localparam int AWT = 4;

  logic clk = 1'b0, rst_n = 1'b0, instr_valid = 1'b0;
  logic [31:0] bus_i = '0;
  logic bank_o, full_n_o, acc_valid_o;
  logic [15:0] ctrl_o, segctl_o, mask1_o, page_src_o, page_dst_o;
  logic [AWT-1:0] addr_o, acc_addr_o;
  logic [3:0] dst_cnt_o, src_cnt_o;

  always #2 clk = ~clk;

  cfg_bank_regfile #(.DEPTH(D)) dut (.*);

  int total = 0, bad = 0;

  // Bench model of the registers
  int m_regs[2][6];
  int m_bank = 0, m_dc = 0, m_sc = 0, m_fn = 1;

  typedef struct {
    int bank; int r[6]; int dc; int sc; int fn; int av; int aa; string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit v, input logic [15:0] op, input logic [15:0] arg, input string tag);
    exp_t e;
    int nb, base, mode;
    @(negedge clk);
    instr_valid = v;
    bus_i = {op, arg};
    nb = m_bank;
    e.av = 0; e.aa = 0;
    if (v) begin
      if (op == 16'h0600) nb = 0;
      else if (op == 16'h0601) nb = 1;
      else if (op == 16'h0602) begin
        m_dc = m_regs[m_bank][1] & 15;
        m_sc = (m_regs[m_bank][1] >> 8) & 15;
      end else if (op == 16'h0700) m_fn = 0;
      else if (op >= 16'h0900 && op <= 16'h0905) begin
        if (op == 16'h0902) m_regs[m_bank][2] = int'(arg) % D;
        else m_regs[m_bank][int'(op) - 16'h0900] = int'(arg);
      end else if (op == 16'h0A00 || op == 16'h0A01) begin
        base = (op == 16'h0A01) ? int'(arg) % D : m_regs[m_bank][2];
        mode = m_regs[m_bank][0] & 3;
        e.av = 1; e.aa = base;
        if (mode == 1) m_regs[m_bank][2] = (base + 1) % D;
        else if (mode == 2) m_regs[m_bank][2] = (base + D - 1) % D;
        else m_regs[m_bank][2] = base;
      end else if (op == 16'h0B00)
        m_dc = (m_dc == ((m_regs[m_bank][1] >> 4) & 15)) ? (m_regs[m_bank][1] & 15) : (m_dc + 1) & 15;
      else if (op == 16'h0B01)
        m_sc = (m_sc == ((m_regs[m_bank][1] >> 12) & 15)) ? ((m_regs[m_bank][1] >> 8) & 15) : (m_sc + 1) & 15;
    end
    m_bank = nb;
    e.bank = m_bank;
    for (int i = 0; i < 6; i++) e.r[i] = m_regs[m_bank][i];
    e.dc = m_dc; e.sc = m_sc; e.fn = m_fn; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per clock after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, "bank", int'(bank_o), e.bank);
        chk(e.tag, "ctrl", int'(ctrl_o), e.r[0]);
        chk(e.tag, "seg", int'(segctl_o), e.r[1]);
        chk(e.tag, "addr", int'(addr_o), e.r[2]);
        chk(e.tag, "mask", int'(mask1_o), e.r[3]);
        chk(e.tag, "psrc", int'(page_src_o), e.r[4]);
        chk(e.tag, "pdst", int'(page_dst_o), e.r[5]);
        chk(e.tag, "dcnt", int'(dst_cnt_o), e.dc);
        chk(e.tag, "scnt", int'(src_cnt_o), e.sc);
        chk(e.tag, "full_n", int'(full_n_o), e.fn);
        chk(e.tag, "acc_v", int'(acc_valid_o), e.av);
        if (e.av != 0) chk(e.tag, "acc_a", int'(acc_addr_o), e.aa);
      end
    end
  end

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < 2; b++) for (int i = 0; i < 6; i++) m_regs[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "bank", int'(bank_o), 0);
    chk("R1", "ctrl", int'(ctrl_o), 0);
    chk("R1", "addr", int'(addr_o), 0);
    chk("R1", "cnt", int'({dst_cnt_o, src_cnt_o}), 0);
    chk("R1", "full_n", int'(full_n_o), 1);
    chk("R1", "acc_v", int'(acc_valid_o), 0);
    // R2 writes into foreground
    drive(1, 16'h0900, 16'h0001, "R2");
    drive(1, 16'h0901, 16'h5263, "R2");
    drive(1, 16'h0902, 16'd11, "R2");
    drive(1, 16'h0903, 16'hA5A5, "R2");
    drive(1, 16'h0904, 16'h1234, "R2");
    drive(1, 16'h0905, 16'hBEEF, "R2");
    drive(1, 16'h0906, 16'h7777, "R2");
    drive(1, 16'h0902, 16'd29, "R2");
    drive(1, 16'h0902, 16'd11, "R2");
    // R6/R7 access with upward wrap and folded load
    drive(1, 16'h0A00, 16'h0000, "R7");
    drive(1, 16'h0A01, 16'd27, "R6");
    drive(1, 16'h0A00, 16'h0000, "R6");
    // R3 background set, switch applies to the very next write
    drive(1, 16'h0601, 16'h0000, "R3");
    drive(1, 16'h0900, 16'h0002, "R3");
    drive(1, 16'h0A00, 16'h0000, "R7");
    drive(1, 16'h0A00, 16'h0000, "R7");
    drive(1, 16'h0901, 16'h0000, "R3");
    drive(1, 16'h0600, 16'h0000, "R3");
    // R4 / R5 counters
    drive(1, 16'h0602, 16'h0000, "R4");
    for (int k = 0; k < 5; k++) drive(1, 16'h0B00, 16'h0000, "R5");
    for (int k = 0; k < 5; k++) drive(1, 16'h0B01, 16'h0000, "R5");
    drive(1, 16'h0602, 16'h0000, "R4");
    // R9 ignored op-codes and idle cycles
    drive(1, 16'h0300, 16'hFFFF, "R9");
    drive(1, 16'h0608, 16'h0000, "R9");
    drive(1, 16'h0603, 16'h0000, "R9");
    drive(0, 16'h0903, 16'h0000, "R9");
    drive(0, 16'h0A01, 16'd5, "R9");
    // R8 full flag sticky
    drive(1, 16'h0700, 16'h0000, "R8");
    drive(1, 16'h0300, 16'h0000, "R8");
    drive(1, 16'h0601, 16'h0000, "R8");
    // Manual-step control mode holds address
    drive(1, 16'h0900, 16'h0003, "R7");
    drive(1, 16'h0A01, 16'd7, "R7");
    drive(0, 16'h0000, 16'h0000, "R9");
    drive(0, 16'h0000, 16'h0000, "R9");
    wait (q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule